// File: doc/BRIEF.md
# EPROM Byte Programming Pulse Sequencer

This block sits on the programmer side of a UV EPROM micro-controller and drives one byte-write operation into the target: a code-array location, an entry of the verify-scrambling table, or one of three lock bits. A command carries the target kind, an address and a data byte. The sequencer presents the address, then the data, then the mode-select control levels. After a setup window it requests the high-voltage programming supply. It then emits a train of active-low programming pulses, releases the supply, holds the address and data for a while longer and reports completion.

All timing comes from one reference clock. Intervals tied to the device oscillator are counted as `SETUP_OSC` periods of `OSC_DIV` reference cycles each. Intervals given in microseconds are counted as `CLK_PER_US` reference cycles per microsecond. The nominal pulse width is 100 µs, the middle of the allowed 90 to 110 µs band. The gap between pulses, the supply lead and the supply lag are each 10 µs.

Commands enter on a valid/ready handshake. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle. A requester that holds `cmd_valid` while `cmd_ready` is low simply waits: the block does not capture that command and keeps no record of it.

Top module: `eprog_seq`

## Requirements
- R1: A command transfers on an edge with `cmd_valid` and `cmd_ready` high. From the next cycle `busy_o` is 1 and `cmd_ready` is 0. Both stay that way until the cycle after the one-cycle `done_o` pulse, when `busy_o` returns to 0 and `cmd_ready` to 1.
- R2: The outputs come up in a fixed order, one per cycle. `dev_addr_o` shows the address in the first cycle after the transfer, `dev_data_o` the data in the second cycle, and `mode_o` the mode levels in the third.
- R3: `mode_o` bit order is {line_a[4], enable[3], line_b[2], line_c[1], line_d[0]}. The target codes map as follows: 0 (code array) gives 5'b01111, 1 (scramble table) gives 5'b01101, 2 (lock bit 1) gives 5'b11111, 3 (lock bit 2) gives 5'b11100 and 4 (lock bit 3) gives 5'b10110.
- R4: `vpp_req_o` rises exactly SETUP_OSC*OSC_DIV reference cycles after `mode_o` first shows the mode levels. `mode_o` does not change while `vpp_req_o` is high.
- R5: The first fall of `prog_n_o` comes exactly VPP_SETUP_US*CLK_PER_US cycles after `vpp_req_o` rises. `prog_n_o` is never low while `vpp_req_o` is low.
- R6: One command produces exactly 5 low pulses for target code 0 and exactly 25 for targets 1 to 4.
- R7: Every low pulse lasts exactly PULSE_US*CLK_PER_US cycles.
- R8: The high time between consecutive pulses is exactly GAP_US*CLK_PER_US cycles.
- R9: `vpp_req_o` falls exactly VPP_HOLD_US*CLK_PER_US cycles after the last rise of `prog_n_o`. `done_o` follows exactly SETUP_OSC*OSC_DIV cycles after that fall, with the address, data and mode still held. In the next cycle all three return to 0.
- R10: A command offered while `busy_o` is 1 is not transferred. It changes neither `dev_addr_o` nor the pulse sequence, and no sequence starts for it after completion.
- R11: Target codes 5, 6 and 7 are consumed while idle without starting a sequence. `busy_o`, `vpp_req_o` and `mode_o` all stay 0.
- R12: After reset `prog_n_o` is 1, `vpp_req_o`, `done_o`, `busy_o`, `dev_addr_o`, `dev_data_o` and `mode_o` are 0, and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can transfer |
| cmd_target | input | 3 | Target kind (codes in R3) |
| cmd_addr | input | ADDR_W | Byte address to program |
| cmd_data | input | DATA_W | Byte value to program |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dev_addr_o | output | ADDR_W | Address lines to the device |
| dev_data_o | output | DATA_W | Data lines to the device |
| mode_o | output | 5 | Mode-select control levels |
| vpp_req_o | output | 1 | Request to raise the programming supply |
| prog_n_o | output | 1 | Active-low programming pulse |

## Verification
The bench runs all five target codes, each with its own nonzero address and data. This separates every mode encoding, and the 5-pulse code-array train from the 25-pulse trains. Address and data extremes (all ones, a single low bit) show that the lines are not altered in flight. Every phase length is measured in cycles against the arithmetic from the parameters, so a shortened pulse or a mis-ordered step stands out from an off-by-one in a single interval. A command offered mid-sequence and the three unused target codes check that neither can start a sequence or disturb the lines.

// File: rtl/eprog_pkg.sv
package eprog_pkg;
  localparam int MODE_W = 5;
  localparam int TGT_W  = 3;

  localparam logic [TGT_W-1:0] TGT_CODE  = 3'd0;
  localparam logic [TGT_W-1:0] TGT_SCRAM = 3'd1;
  localparam logic [TGT_W-1:0] TGT_LOCK1 = 3'd2;
  localparam logic [TGT_W-1:0] TGT_LOCK2 = 3'd3;
  localparam logic [TGT_W-1:0] TGT_LOCK3 = 3'd4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_MODE, ST_RAMP,
    ST_LOW, ST_GAP, ST_VHOLD, ST_AHOLD, ST_DONE
  } seq_st_e;

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/eprog_mode_dec.sv
module eprog_mode_dec
  import eprog_pkg::*;
(
  input  logic [TGT_W-1:0]  tgt,
  output logic [MODE_W-1:0] lines,
  output logic              tgt_ok,
  output logic              long_train
);
  always_comb begin
    lines      = '0;
    tgt_ok     = 1'b1;
    long_train = 1'b1;
    unique case (tgt)
      TGT_CODE:  begin lines = 5'b01111; long_train = 1'b0; end
      TGT_SCRAM: lines = 5'b01101;
      TGT_LOCK1: lines = 5'b11111;
      TGT_LOCK2: lines = 5'b11100;
      TGT_LOCK3: lines = 5'b10110;
      default:   begin tgt_ok = 1'b0; long_train = 1'b0; end
    endcase
  end
endmodule

// File: rtl/eprog_timer.sv
module eprog_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R7: an expired timer stays expired until reloaded (no wrap)
  a_r7_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/eprog_pulse_cnt.sv
module eprog_pulse_cnt #(
  parameter int SHORT_PULSES = 5,
  parameter int LONG_PULSES  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  input  logic long_sel,
  output logic last
);
  localparam int PC_W = $clog2(LONG_PULSES + 1);

  logic [PC_W-1:0] count_q;
  logic [PC_W-1:0] limit;

  assign limit = long_sel ? PC_W'(LONG_PULSES) : PC_W'(SHORT_PULSES);
  assign last  = (count_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (inc)  count_q <= count_q + 1'b1;
  end

  // R6: the pulse count never passes the train length of the target
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= limit);
endmodule

// File: rtl/eprog_seq.sv
module eprog_seq
  import eprog_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int DATA_W       = 8,
  parameter int CLK_PER_US   = 4,
  parameter int OSC_DIV      = 2,
  parameter int SETUP_OSC    = 48,
  parameter int PULSE_US     = 100,
  parameter int GAP_US       = 10,
  parameter int VPP_SETUP_US = 10,
  parameter int VPP_HOLD_US  = 10,
  parameter int SHORT_PULSES = 5,
  parameter int LONG_PULSES  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_target,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_data_o,
  output logic [4:0]        mode_o,
  output logic              vpp_req_o,
  output logic              prog_n_o
);
  localparam int T_SET  = SETUP_OSC * OSC_DIV;
  localparam int T_VS   = VPP_SETUP_US * CLK_PER_US;
  localparam int T_LOW  = PULSE_US * CLK_PER_US;
  localparam int T_GAP  = GAP_US * CLK_PER_US;
  localparam int T_VH   = VPP_HOLD_US * CLK_PER_US;
  localparam int T_MAX  = max_of2(max_of2(T_SET, T_VS),
                                  max_of2(T_LOW, max_of2(T_GAP, T_VH)));
  localparam int CNT_W  = $clog2(T_MAX) + 1;

  seq_st_e            st_q, st_d;
  logic               tmr_load, tmr_exp;
  logic [CNT_W-1:0]   tmr_val;
  logic               pc_clr, pc_inc, pc_last;
  logic [MODE_W-1:0]  dec_lines;
  logic               dec_ok, dec_long;
  logic [MODE_W-1:0]  mode_q;
  logic               long_q;
  logic [DATA_W-1:0]  data_q;
  logic               accept;
  logic               vpp_d;

  eprog_mode_dec i_dec (
    .tgt        (cmd_target),
    .lines      (dec_lines),
    .tgt_ok     (dec_ok),
    .long_train (dec_long)
  );

  eprog_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  eprog_pulse_cnt #(
    .SHORT_PULSES (SHORT_PULSES),
    .LONG_PULSES  (LONG_PULSES)
  ) i_pcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pc_clr),
    .inc      (pc_inc),
    .long_sel (long_q),
    .last     (pc_last)
  );

  assign cmd_ready = !busy_o;
  assign accept    = cmd_valid && cmd_ready && dec_ok;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    pc_clr   = 1'b0;
    pc_inc   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_ADDR;
        pc_clr = 1'b1;
      end
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        st_d = ST_MODE; tmr_load = 1'b1; tmr_val = CNT_W'(T_SET - 1);
      end
      ST_MODE: if (tmr_exp) begin
        st_d = ST_RAMP; tmr_load = 1'b1; tmr_val = CNT_W'(T_VS - 1);
      end
      ST_RAMP: if (tmr_exp) begin
        st_d = ST_LOW; tmr_load = 1'b1; tmr_val = CNT_W'(T_LOW - 1);
      end
      ST_LOW: if (tmr_exp) begin
        pc_inc   = 1'b1;
        tmr_load = 1'b1;
        if (pc_last) begin
          st_d = ST_VHOLD; tmr_val = CNT_W'(T_VH - 1);
        end else begin
          st_d = ST_GAP;   tmr_val = CNT_W'(T_GAP - 1);
        end
      end
      ST_GAP: if (tmr_exp) begin
        st_d = ST_LOW; tmr_load = 1'b1; tmr_val = CNT_W'(T_LOW - 1);
      end
      ST_VHOLD: if (tmr_exp) begin
        st_d = ST_AHOLD; tmr_load = 1'b1; tmr_val = CNT_W'(T_SET - 1);
      end
      ST_AHOLD: if (tmr_exp) st_d = ST_DONE;
      ST_DONE: begin
        st_d   = ST_IDLE;
        pc_clr = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign vpp_d = (st_d == ST_RAMP) || (st_d == ST_LOW) ||
                 (st_d == ST_GAP)  || (st_d == ST_VHOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      mode_q     <= '0;
      long_q     <= 1'b0;
      data_q     <= '0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      dev_addr_o <= '0;
      dev_data_o <= '0;
      mode_o     <= '0;
      vpp_req_o  <= 1'b0;
      prog_n_o   <= 1'b1;
    end else begin
      st_q      <= st_d;
      busy_o    <= (st_d != ST_IDLE);
      done_o    <= (st_d == ST_DONE);
      vpp_req_o <= vpp_d;
      prog_n_o  <= (st_d != ST_LOW);
      if (accept) begin
        mode_q <= dec_lines;
        long_q <= dec_long;
        data_q <= cmd_data;
      end
      if (st_d == ST_IDLE)  dev_addr_o <= '0;
      else if (accept)      dev_addr_o <= cmd_addr;
      if (st_d == ST_IDLE)       dev_data_o <= '0;
      else if (st_d == ST_DATA)  dev_data_o <= data_q;
      if (st_d == ST_IDLE)       mode_o <= '0;
      else if (st_d == ST_MODE)  mode_o <= mode_q;
    end
  end

  // R5: no programming pulse without the supply request
  a_r5_prog_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> vpp_req_o);

  // R4: mode levels frozen while the supply is requested
  a_r4_mode_frozen_under_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_req_o |=> $stable(mode_o));

  // R10: address lines untouched by any command during a sequence
  a_r10_addr_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(dev_addr_o));

  // R9: completion is a single cycle with the supply off and PROG high
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!vpp_req_o && prog_n_o));

  // R11: an unused target code never starts a sequence
  a_r11_bad_target_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !dec_ok) |=> !busy_o);
endmodule

// File: tb/test_eprog_seq.sv
`timescale 1ns/1ps
module test_eprog_seq;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 8;
  localparam int CPU    = 4;
  localparam int ODIV   = 2;
  localparam int SOSC   = 48;
  localparam int T_SET  = SOSC * ODIV;
  localparam int T_VS   = 10 * CPU;
  localparam int T_LOW  = 100 * CPU;
  localparam int T_GAP  = 10 * CPU;
  localparam int T_VH   = 10 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_target = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic busy_o, done_o, vpp_req_o, prog_n_o;
  logic [ADDR_W-1:0] dev_addr_o;
  logic [DATA_W-1:0] dev_data_o;
  logic [4:0] mode_o;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  eprog_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PER_US(CPU), .OSC_DIV(ODIV),
    .SETUP_OSC(SOSC), .PULSE_US(100), .GAP_US(10), .VPP_SETUP_US(10),
    .VPP_HOLD_US(10), .SHORT_PULSES(5), .LONG_PULSES(25)
  ) i_eprog_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_target(cmd_target), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .busy_o(busy_o), .done_o(done_o), .dev_addr_o(dev_addr_o),
    .dev_data_o(dev_data_o), .mode_o(mode_o), .vpp_req_o(vpp_req_o),
    .prog_n_o(prog_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_mode(input logic [2:0] t);
    case (t)
      3'd0: return 5'b01111;
      3'd1: return 5'b01101;
      3'd2: return 5'b11111;
      3'd3: return 5'b11100;
      3'd4: return 5'b10110;
      default: return 5'b00000;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic run_seq(input logic [2:0] t, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input bit poke);
    int k_addr = -1, k_data = -1, k_mode = -1, k_vrise = -1, k_vfall = -1;
    int first_fall = -1, last_rise = -1, fall_k = 0, k_done = -1;
    int pulses = 0, bad_low = 0, bad_gap = 0, bad_hold = 0;
    int npul;
    logic pp, pv;
    npul = (t == 3'd0) ? 5 : 25;
    @(negedge clk);
    cmd_target = t; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
    chk(cmd_ready == 1'b1, "R1 ready before transfer", cmd_ready, 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy_o == 1'b1 && cmd_ready == 1'b0, "R1 busy after transfer", busy_o, 1);
    pp = 1'b1; pv = 1'b0;
    for (int k = 0; k < 20000; k++) begin
      if (k > 0) @(negedge clk);
      if (k_addr < 0 && dev_addr_o == a) k_addr = k;
      if (k_data < 0 && dev_data_o == d) k_data = k;
      if (k_mode < 0 && mode_o == exp_mode(t)) k_mode = k;
      if (vpp_req_o && !pv) k_vrise = k;
      if (!vpp_req_o && pv) k_vfall = k;
      if (!prog_n_o && pp) begin
        pulses++;
        if (first_fall < 0) first_fall = k;
        if (last_rise >= 0 && (k - last_rise) != T_GAP) bad_gap++;
        fall_k = k;
      end
      if (prog_n_o && !pp) begin
        if ((k - fall_k) != T_LOW) bad_low++;
        last_rise = k;
      end
      if (!prog_n_o && (dev_addr_o != a || dev_data_o != d || mode_o != exp_mode(t)))
        bad_hold++;
      pp = prog_n_o; pv = vpp_req_o;
      if (poke && k == 60) begin
        chk(cmd_ready == 1'b0, "R10 ready low mid-sequence", cmd_ready, 0);
        cmd_valid = 1'b1; cmd_addr = ~a; cmd_target = 3'd2;
      end
      if (poke && k == 61) cmd_valid = 1'b0;
      if (done_o) begin k_done = k; break; end
    end
    chk(k_addr == 0, "R2 address first", k_addr, 0);
    chk(k_data == 1, "R2 data second", k_data, 1);
    chk(k_mode == 2, "R3 mode encoding and third step", k_mode, 2);
    chk(k_vrise - k_mode == T_SET, "R4 mode to supply setup", k_vrise - k_mode, T_SET);
    chk(first_fall - k_vrise == T_VS, "R5 supply lead", first_fall - k_vrise, T_VS);
    chk(pulses == npul, "R6 pulse count", pulses, npul);
    chk(bad_low == 0, "R7 pulse width", bad_low, 0);
    chk(bad_gap == 0, "R8 pulse gap", bad_gap, 0);
    chk(bad_hold == 0, "R10 lines held under pulses", bad_hold, 0);
    chk(k_vfall - last_rise == T_VH, "R9 supply lag", k_vfall - last_rise, T_VH);
    chk(k_done - k_vfall == T_SET, "R9 address hold to done", k_done - k_vfall, T_SET);
    chk(dev_addr_o == a && dev_data_o == d, "R9 lines held at done", dev_addr_o, a);
    @(negedge clk);
    chk(!done_o && !busy_o && cmd_ready, "R1 idle after done", busy_o, 0);
    chk(dev_addr_o == '0 && dev_data_o == '0 && mode_o == '0, "R9 lines cleared",
        mode_o, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(!busy_o && prog_n_o && !vpp_req_o, "R10 no queued start", busy_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_n_o == 1'b1, "R12 reset prog_n", prog_n_o, 1);
    chk(!vpp_req_o && !done_o && !busy_o, "R12 reset flags", vpp_req_o, 0);
    chk(dev_addr_o == '0 && dev_data_o == '0 && mode_o == '0, "R12 reset lines",
        mode_o, 0);
    chk(cmd_ready == 1'b1, "R12 reset ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: unused target codes
    for (int t = 5; t < 8; t++) begin
      cmd_target = 3'(t); cmd_addr = 14'h0155; cmd_data = 8'h3C; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b1 && !busy_o, "R11 bad target not started", busy_o, 0);
      repeat (3) @(negedge clk);
      chk(!vpp_req_o && mode_o == '0 && dev_addr_o == '0, "R11 lines quiet",
          mode_o, 0);
    end

    // sweep all targets
    for (int t = 0; t < 5; t++)
      run_seq(3'(t), 14'h1234 ^ 14'(t * 37), 8'hA5 + 8'(t * 9), 1'b0);
    run_seq(3'd0, 14'h3FFF, 8'hFF, 1'b0);
    run_seq(3'd0, 14'h3FFE, 8'hFE, 1'b1);
    run_seq(3'd3, 14'h0001, 8'h01, 1'b1);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule